// File: doc/BRIEF.md
# Indirect PHY Register Access Bridge

This block gives a host register bus a window onto a small 8-bit PHY register space. The PHY registers are not mapped into host space. Software uses two host registers: a command register that holds the PHY register offset and a direction flag, and a data register that holds one byte.

For a PHY write, software first loads the byte into the data register. It then writes the offset to the command register with the direction flag set. For a PHY read, software clears the data register and writes the offset with the direction flag clear. In both cases it then polls the busy flag in the command register until it reads 0. After a read, the returned byte is in the low byte of the data register.

On the PHY side the bridge raises a request and holds it, with address, direction and write data stable, until the PHY acknowledges.

Top module: `phy_reg_bridge`

## Requirements
- R1: After reset, no PHY request is pending, and both the command register and the data register read as 0.
- R2: The command register is at host offset 0x300 and the data register at 0x304. Reads of any other offset return 0, and writes to any other offset change nothing and start no transaction.
- R3: The data register holds 8 bits, taken from write-data bits 7:0. It reads back in bits 7:0, and bits 31:8 read as 0.
- R4: A command-register write while idle starts a transaction. From the next cycle, the request is high, the PHY address equals write-data bits 7:0, and the PHY direction equals write-data bit 8 (1 = write, 0 = read).
- R5: For a PHY write, the PHY write data equals the data-register value at the moment the command register was written.
- R6: Once raised, the request stays high until a cycle with the acknowledge high. While it is held, the PHY address, direction and write data do not change.
- R7: The edge on which the acknowledge is seen with the request high ends the transaction. From the next cycle, busy and the request are low, and for a read the data register holds the PHY read byte. An acknowledge with no request pending has no effect.
- R8: The acknowledge of a PHY write leaves the data register unchanged.
- R9: A command-register write while busy is ignored. Offset, direction and the pending transaction are unchanged, and no second transaction follows.
- R10: A host write to the data register while busy updates the data register but not the PHY write data of the pending transaction.
- R11: When a read acknowledge and a host data-register write fall on the same edge, the PHY read byte is stored.
- R12: The command register reads back with the offset in bits 7:0, the direction in bit 8, busy in bit 9, and 0 in all other bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busWrEn | input | 1 | Host write strobe |
| busRdEn | input | 1 | Host read strobe |
| busAddr | input | 12 | Host register offset |
| busWrData | input | 32 | Host write data |
| busRdData | output | 32 | Host read data, valid in the cycle of busRdEn |
| phyReq | output | 1 | PHY request, high while busy |
| phyWr | output | 1 | PHY direction, 1 = write |
| phyAddr | output | 8 | PHY register offset |
| phyWrData | output | 8 | PHY write byte |
| phyAck | input | 1 | PHY acknowledge |
| phyRdData | input | 8 | PHY read byte, sampled with phyAck |

## Verification
The bench goes after each of these corner cases:
- **Command write while busy.** A design that accepts it would move the PHY address in mid-request or run a second transaction.
- **Data write while a PHY write is pending.** A design that drives the PHY straight from the data register would change the write byte before the acknowledge.
- **Read acknowledge on the same edge as a host data write.** A design with the wrong priority would return the host byte instead of the PHY byte.
- **Acknowledge of a PHY write, and an acknowledge while idle.** Each arrives with a non-zero read byte, so a design that captures on every acknowledge corrupts the data register.
- **Acknowledge delay of zero cycles and of several cycles.** A design that drops the request early, or lets busy lag by one cycle, shows wrong busy or request values.

// File: rtl/phy_bridge_pkg.sv
package phy_bridge_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } brState_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic launch;   // latch command fields and write byte
    logic capture;  // store PHY read byte into data register
  } brStrobe_t;
endpackage

// File: rtl/phy_bridge_ctrl.sv
module phy_bridge_ctrl
  import phy_bridge_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      cmdWrHit,
  input  logic      phyAck,
  input  logic      isWrite,
  output brStrobe_t strobe,
  output logic      busy
);
  brState_t stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    strobe = '0;
    case (stateQ)
      ST_IDLE: begin
        if (cmdWrHit) begin
          strobe.launch = 1'b1;
          stateD = ST_WAIT;
        end
      end
      ST_WAIT: begin
        // Command writes are ignored here; only the acknowledge matters.
        if (phyAck) begin
          strobe.capture = !isWrite;
          stateD = ST_IDLE;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  assign busy = (stateQ == ST_WAIT);
endmodule

// File: rtl/phy_bridge_dp.sv
module phy_bridge_dp
  import phy_bridge_pkg::*;
#(
  parameter int BUS_DATA_W = 32,
  parameter int PHY_ADDR_W = 8,
  parameter int PHY_DATA_W = 8,
  parameter int WR_BIT     = 8,
  parameter int BUSY_BIT   = 9
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  brStrobe_t             strobe,
  input  logic                  busy,
  input  logic                  dataWrHit,
  input  logic                  cmdRdSel,
  input  logic                  dataRdSel,
  input  logic                  busRdEn,
  input  logic [BUS_DATA_W-1:0] busWrData,
  input  logic [PHY_DATA_W-1:0] phyRdData,
  output logic [BUS_DATA_W-1:0] busRdData,
  output logic [PHY_ADDR_W-1:0] phyAddr,
  output logic                  phyWr,
  output logic [PHY_DATA_W-1:0] phyWrData,
  output logic                  isWrite,
  output logic [PHY_DATA_W-1:0] dataVal
);
  logic [PHY_ADDR_W-1:0] cmdOfsQ;
  logic                  cmdWrQ;
  logic [PHY_DATA_W-1:0] dataQ;
  logic [PHY_DATA_W-1:0] launchDataQ;
  logic [BUS_DATA_W-1:0] cmdWord, dataWord;
  logic                  unusedWrBits;

  assign unusedWrBits = ^busWrData;

  // Command fields and launch copy: loaded only when a transaction starts.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdOfsQ     <= '0;
      cmdWrQ      <= 1'b0;
      launchDataQ <= '0;
    end else if (strobe.launch) begin
      cmdOfsQ     <= busWrData[PHY_ADDR_W-1:0];
      cmdWrQ      <= busWrData[WR_BIT];
      launchDataQ <= dataQ;
    end
  end

  // Data register: PHY capture takes priority over a host write.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               dataQ <= '0;
    else if (strobe.capture) dataQ <= phyRdData;
    else if (dataWrHit)      dataQ <= busWrData[PHY_DATA_W-1:0];
  end

  always_comb begin
    cmdWord = '0;
    cmdWord[PHY_ADDR_W-1:0] = cmdOfsQ;
    cmdWord[WR_BIT]         = cmdWrQ;
    cmdWord[BUSY_BIT]       = busy;
    dataWord = '0;
    dataWord[PHY_DATA_W-1:0] = dataQ;
  end

  always_comb begin
    busRdData = '0;
    if (busRdEn) begin
      if (cmdRdSel)       busRdData = cmdWord;
      else if (dataRdSel) busRdData = dataWord;
    end
  end

  assign phyAddr   = cmdOfsQ;
  assign phyWr     = cmdWrQ;
  assign phyWrData = launchDataQ;
  assign isWrite   = cmdWrQ;
  assign dataVal   = dataQ;
endmodule

// File: rtl/phy_reg_bridge.sv
module phy_reg_bridge
  import phy_bridge_pkg::*;
#(
  parameter int BUS_ADDR_W = 12,
  parameter int BUS_DATA_W = 32,
  parameter int PHY_ADDR_W = 8,
  parameter int PHY_DATA_W = 8,
  parameter int CMD_OFS    = 'h300,
  parameter int DATA_OFS   = 'h304,
  parameter int WR_BIT     = 8,
  parameter int BUSY_BIT   = 9
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  busWrEn,
  input  logic                  busRdEn,
  input  logic [BUS_ADDR_W-1:0] busAddr,
  input  logic [BUS_DATA_W-1:0] busWrData,
  output logic [BUS_DATA_W-1:0] busRdData,
  output logic                  phyReq,
  output logic                  phyWr,
  output logic [PHY_ADDR_W-1:0] phyAddr,
  output logic [PHY_DATA_W-1:0] phyWrData,
  input  logic                  phyAck,
  input  logic [PHY_DATA_W-1:0] phyRdData
);
  localparam logic [BUS_ADDR_W-1:0] CmdAddr  = BUS_ADDR_W'(CMD_OFS);
  localparam logic [BUS_ADDR_W-1:0] DataAddr = BUS_ADDR_W'(DATA_OFS);

  logic                  cmdSel, dataSel, busy, isWrite;
  logic [PHY_DATA_W-1:0] dataVal;
  brStrobe_t             strobe;

  assign cmdSel  = (busAddr == CmdAddr);
  assign dataSel = (busAddr == DataAddr);

  phy_bridge_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdWrHit (busWrEn && cmdSel),
    .phyAck   (phyAck),
    .isWrite  (isWrite),
    .strobe   (strobe),
    .busy     (busy)
  );

  phy_bridge_dp #(
    .BUS_DATA_W (BUS_DATA_W),
    .PHY_ADDR_W (PHY_ADDR_W),
    .PHY_DATA_W (PHY_DATA_W),
    .WR_BIT     (WR_BIT),
    .BUSY_BIT   (BUSY_BIT)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .busy      (busy),
    .dataWrHit (busWrEn && dataSel),
    .cmdRdSel  (cmdSel),
    .dataRdSel (dataSel),
    .busRdEn   (busRdEn),
    .busWrData (busWrData),
    .phyRdData (phyRdData),
    .busRdData (busRdData),
    .phyAddr   (phyAddr),
    .phyWr     (phyWr),
    .phyWrData (phyWrData),
    .isWrite   (isWrite),
    .dataVal   (dataVal)
  );

  assign phyReq = busy;
endmodule

// File: rtl/phy_reg_bridge_chk.sv
module phy_reg_bridge_chk #(
  parameter int BUS_ADDR_W = 12,
  parameter int BUS_DATA_W = 32,
  parameter int PHY_ADDR_W = 8,
  parameter int PHY_DATA_W = 8,
  parameter int CMD_OFS    = 'h300,
  parameter int DATA_OFS   = 'h304
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  busWrEn,
  input logic [BUS_ADDR_W-1:0] busAddr,
  input logic [BUS_DATA_W-1:0] busWrData,
  input logic                  phyReq,
  input logic                  phyWr,
  input logic [PHY_ADDR_W-1:0] phyAddr,
  input logic [PHY_DATA_W-1:0] phyWrData,
  input logic                  phyAck,
  input logic [PHY_DATA_W-1:0] phyRdData,
  input logic [PHY_DATA_W-1:0] dataVal
);
  logic cmdWr, dataWr;
  assign cmdWr  = busWrEn && (busAddr == BUS_ADDR_W'(CMD_OFS));
  assign dataWr = busWrEn && (busAddr == BUS_ADDR_W'(DATA_OFS));

  p_launch_r4: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && !phyReq) |=> (phyReq && phyAddr == $past(busWrData[PHY_ADDR_W-1:0])));

  p_wrbyte_r5: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && !phyReq) |=> (phyWrData == $past(dataVal)));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (phyReq && !phyAck) |=> phyReq);

  p_stable_r6: assert property (@(posedge clk) disable iff (!rstN)
    (phyReq && !phyAck) |=> ($stable(phyAddr) && $stable(phyWr) && $stable(phyWrData)));

  p_ackclear_r7: assert property (@(posedge clk) disable iff (!rstN)
    (phyReq && phyAck) |=> !phyReq);

  // Also covers R11: capture wins over a host data write on the same edge.
  p_capture_r7: assert property (@(posedge clk) disable iff (!rstN)
    (phyReq && phyAck && !phyWr) |=> (dataVal == $past(phyRdData)));

  p_wrack_keep_r8: assert property (@(posedge clk) disable iff (!rstN)
    (phyReq && phyAck && phyWr && !dataWr) |=> $stable(dataVal));

  p_idle_ack_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!phyReq && phyAck && !dataWr && !cmdWr) |=> ($stable(dataVal) && !phyReq));
endmodule

bind phy_reg_bridge phy_reg_bridge_chk #(
  .BUS_ADDR_W (BUS_ADDR_W),
  .BUS_DATA_W (BUS_DATA_W),
  .PHY_ADDR_W (PHY_ADDR_W),
  .PHY_DATA_W (PHY_DATA_W),
  .CMD_OFS    (CMD_OFS),
  .DATA_OFS   (DATA_OFS)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busWrEn   (busWrEn),
  .busAddr   (busAddr),
  .busWrData (busWrData),
  .phyReq    (phyReq),
  .phyWr     (phyWr),
  .phyAddr   (phyAddr),
  .phyWrData (phyWrData),
  .phyAck    (phyAck),
  .phyRdData (phyRdData),
  .dataVal   (dataVal)
);

// File: tb/tb_phy_reg_bridge.sv
module tb_phy_reg_bridge;
  localparam logic [11:0] CMD  = 12'h300;
  localparam logic [11:0] DATA = 12'h304;

  typedef struct packed {
    logic       isWr;
    logic [7:0] ofs;
    logic [7:0] wdat;
    logic [7:0] rdat;
    logic [3:0] gap;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{1'b1, 8'h0C, 8'h15, 8'hEE, 4'd0},
    '{1'b0, 8'h03, 8'h00, 8'h10, 4'd2},
    '{1'b1, 8'h3F, 8'hA5, 8'h5A, 4'd5},
    '{1'b0, 8'h00, 8'h00, 8'hC3, 4'd0},
    '{1'b1, 8'h24, 8'hFF, 8'h01, 4'd1},
    '{1'b0, 8'h22, 8'h00, 8'h7E, 4'd7}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0, busRdEn = 1'b0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        phyReq, phyWr;
  logic [7:0]  phyAddr, phyWrData;
  logic        phyAck = 1'b0;
  logic [7:0]  phyRdData = '0;

  int nChk = 0, nFail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  phy_reg_bridge dut (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .phyReq(phyReq), .phyWr(phyWr), .phyAddr(phyAddr), .phyWrData(phyWrData),
    .phyAck(phyAck), .phyRdData(phyRdData)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    busAddr = a; busRdEn = 1'b1;
    #1 d = busRdData;
    busRdEn = 1'b0;
  endtask

  task automatic ackPulse(input logic [7:0] v);
    phyAck = 1'b1; phyRdData = v;
    @(negedge clk);
    phyAck = 1'b0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [31:0] r;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 req", {31'b0, phyReq}, 32'h0);
    rd(CMD, r);  chk("R1 cmd", r, 32'h0);
    rd(DATA, r); chk("R1 data", r, 32'h0);
    rstN = 1'b1;

    // Vector table walk: R4 R5 R6 R7 R8 R12
    for (int i = 0; i < 6; i++) begin
      wr(DATA, VEC[i].isWr ? {24'h0, VEC[i].wdat} : 32'h0);
      wr(CMD, {23'b0, VEC[i].isWr, VEC[i].ofs});
      chk("R4 req", {31'b0, phyReq}, 32'h1);
      chk("R4 addr", {24'b0, phyAddr}, {24'b0, VEC[i].ofs});
      chk("R4 dir", {31'b0, phyWr}, {31'b0, VEC[i].isWr});
      if (VEC[i].isWr) chk("R5 wbyte", {24'b0, phyWrData}, {24'b0, VEC[i].wdat});
      rd(CMD, r);
      chk("R12 cmd busy", r, {22'b0, 1'b1, VEC[i].isWr, VEC[i].ofs});
      for (int g = 0; g < VEC[i].gap; g++) @(negedge clk);
      chk("R6 held", {31'b0, phyReq}, 32'h1);
      chk("R6 addr", {24'b0, phyAddr}, {24'b0, VEC[i].ofs});
      ackPulse(VEC[i].rdat);
      chk("R7 req clr", {31'b0, phyReq}, 32'h0);
      rd(CMD, r);
      chk("R12 cmd idle", r, {22'b0, 1'b0, VEC[i].isWr, VEC[i].ofs});
      rd(DATA, r);
      if (VEC[i].isWr) chk("R8 data kept", r, {24'b0, VEC[i].wdat});
      else             chk("R7 capture", r, {24'b0, VEC[i].rdat});
    end

    // R3: only low byte stored
    wr(DATA, 32'hABCD_EF5A);
    rd(DATA, r); chk("R3 low byte", r, 32'h0000_005A);

    // R2: unmapped offsets
    wr(12'h308, 32'hFFFF_FFFF);
    wr(12'h000, 32'h0000_0133);
    chk("R2 no txn", {31'b0, phyReq}, 32'h0);
    rd(12'h308, r); chk("R2 unmapped rd", r, 32'h0);
    rd(12'h200, r); chk("R2 unmapped rd2", r, 32'h0);
    rd(DATA, r);    chk("R2 data untouched", r, 32'h5A);

    // R9: command write while busy
    wr(DATA, 32'h0);
    wr(CMD, 32'h0000_0011);
    wr(CMD, 32'h0000_0122);
    chk("R9 addr", {24'b0, phyAddr}, 32'h11);
    chk("R9 dir", {31'b0, phyWr}, 32'h0);
    rd(CMD, r); chk("R9 cmd", r, 32'h0000_0211);
    ackPulse(8'h6B);
    repeat (2) @(negedge clk);
    chk("R9 no second txn", {31'b0, phyReq}, 32'h0);
    rd(DATA, r); chk("R9 read byte", r, 32'h6B);

    // R10: data write while a PHY write is pending
    wr(DATA, 32'h3C);
    wr(CMD, 32'h0000_010D);
    wr(DATA, 32'h77);
    chk("R10 wbyte", {24'b0, phyWrData}, 32'h3C);
    rd(DATA, r); chk("R10 data reg", r, 32'h77);
    ackPulse(8'h00);
    rd(DATA, r); chk("R10 after ack", r, 32'h77);

    // R11: capture versus same-edge host write
    wr(CMD, 32'h0000_0003);
    phyAck = 1'b1; phyRdData = 8'h99;
    busWrEn = 1'b1; busAddr = DATA; busWrData = 32'h55;
    @(negedge clk);
    phyAck = 1'b0; busWrEn = 1'b0;
    rd(DATA, r); chk("R11 capture wins", r, 32'h99);

    // R7: acknowledge while idle
    ackPulse(8'h42);
    chk("R7 idle ack req", {31'b0, phyReq}, 32'h0);
    rd(DATA, r); chk("R7 idle ack data", r, 32'h99);

    repeat (2) @(negedge clk);
    summary();
  end
endmodule